// File: doc/BRIEF.md
# Legacy Instruction Prefix Scanner

This block sits at the front of an instruction decoder. It takes instruction bytes one per cycle over a valid/ready handshake and walks the leading legacy prefix bytes. It keeps a running record of the operand-size override, the repeat prefix, the mandatory (SIMD) prefix class and any segment override. The first byte that is not a prefix ends the scan. That byte is reported as the opcode together with the collected prefix state. The result is held on the output until a consumer accepts it.

The mandatory class follows a fixed priority. A repeat prefix (F2 or F3) always takes the class, and the last one wins. The operand-size byte (66) claims the class only while no class has been set yet. When both kinds are present, the instruction is still decoded, and the repeat prefix decides the class no matter where it sits in the byte order.

When the opcode is the two-byte escape, the scanner also takes the following byte. It flags whether the pair selects the aligned 128-bit vector load variant or the unaligned one. A run of prefixes too long for a legal instruction ends the instruction with a fault.

Top module: `pfx_scan`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: A byte is taken on a clock edge where in_valid and in_ready are both 1. in_ready equals the inverse of out_valid. While out_valid is 1 and out_ready is 0, every result output stays unchanged. The result is consumed on the edge where out_valid and out_ready are both 1.
- R3: out_opsize is 4 when cfg_op4 is 1 and 2 when it is 0. If at least one 0x66 byte was seen in the instruction, it takes the other of those two values. cfg_op4 is sampled when the result is produced.
- R4: Byte 0x66 sets out_class to 0x66 only if the class is still 0x00. Otherwise the class is left as it is.
- R5: Bytes 0xF2 and 0xF3 each overwrite both out_rep and out_class with their own value, so the last one seen wins. out_rep is 0x00 when neither byte occurred.
- R6: Any mix of 0x66 with 0xF2/0xF3, in any order or count, gives the class of the last 0xF2/0xF3 and no fault.
- R7: The first byte that is not 0x66, 0xF2, 0xF3 or a segment byte is reported on out_opcode. out_class is one of 0x00 (no mandatory prefix), 0x66, 0xF2 or 0xF3.
- R8: If the opcode is 0x0F, the next byte is also taken and shown on out_esc2; otherwise out_esc2 is 0x00. For 0x0F 0x6F, out_vload_aligned is 1 when the class is 0x66 and out_vload_unaligned is 1 when the class is 0xF3. In all other cases both flags are 0.
- R9: Segment bytes 0x26, 0x2E, 0x36, 0x3E, 0x64 and 0x65 are prefixes. They set out_seg_ovr to 1, and out_seg holds the last one seen. With no segment byte, out_seg_ovr and out_seg are 0.
- R10: All prefix state returns to its defaults (class 0x00, rep 0x00, no size override, no segment) for each new instruction, including the one after a fault.
- R11: If a 15th prefix byte arrives in a row, the instruction ends with out_fault = 1. That byte is shown on out_opcode, and out_esc2 is 0x00. The state shown is built from the first 14 prefixes only. Fourteen prefixes followed by an opcode byte give no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_op4 | input | 1 | Default operand size: 1 for 4 bytes, 0 for 2 bytes |
| in_valid | input | 1 | Instruction byte is valid |
| in_ready | output | 1 | Scanner can take a byte |
| in_byte | input | 8 | Instruction byte |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Consumer takes the result |
| out_opsize | output | 3 | Effective operand size in bytes (2 or 4) |
| out_rep | output | 8 | Repeat prefix: 0x00, 0xF2 or 0xF3 |
| out_class | output | 8 | Mandatory prefix class: 0x00, 0x66, 0xF2 or 0xF3 |
| out_seg_ovr | output | 1 | A segment override was seen |
| out_seg | output | 8 | Last segment override byte |
| out_opcode | output | 8 | First non-prefix byte, or the faulting prefix byte |
| out_esc2 | output | 8 | Byte after the 0x0F escape, else 0x00 |
| out_vload_aligned | output | 1 | 0x0F 0x6F decoded as the aligned vector load |
| out_vload_unaligned | output | 1 | 0x0F 0x6F decoded as the unaligned vector load |
| out_fault | output | 1 | Prefix run exceeded the length limit |

## Verification
Some properties are checked by assertions on every cycle while a result is shown. These are: the result is held stable while it waits, the class takes only one of its four codes, a non-zero repeat prefix always equals the class, the size is always one of the two legal values, the two load flags never assert together, and the opcode field holds a prefix byte only on a fault. The bench scenarios cover what those properties cannot. These are the order-independent win of F2/F3 over 66 in every three-byte ordering, 66 claiming the class only while it is empty, the segment byte that was seen last, the clearing of state between back-to-back instructions and after a fault, and the exact boundary between 14 and 15 prefix bytes.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

   localparam logic [7:0] B_OSZ    = 8'h66;
   localparam logic [7:0] B_REPNE  = 8'hF2;
   localparam logic [7:0] B_REPE   = 8'hF3;
   localparam logic [7:0] CLS_NONE = 8'h00;

   localparam int NUM_SEG = 6;
   localparam logic [NUM_SEG*8-1:0] SEG_CODES = {8'h65, 8'h64, 8'h3E, 8'h36, 8'h2E, 8'h26};

   typedef enum logic [1:0] {K_OPC, K_OSZ, K_REP, K_SEG} kind_e;

   typedef enum logic {S_SCAN, S_ESC} scan_st_e;

   typedef struct packed {
      logic       osz;
      logic [7:0] rep;
      logic [7:0] cls;
      logic       seg_f;
      logic [7:0] seg_b;
   } acc_t;

   localparam acc_t ACC_CLR = '{osz: 1'b0, rep: 8'h00, cls: 8'h00, seg_f: 1'b0, seg_b: 8'h00};

endpackage

// File: rtl/pfx_classify.sv
module pfx_classify
   import pfx_pkg::*;
(
   input  logic [7:0] byte_i,
   output kind_e      kind_o
);

   logic [NUM_SEG-1:0] seg_hit;

   for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
      assign seg_hit[g] = (byte_i == SEG_CODES[g*8 +: 8]);
   end

   always_comb begin
      if (byte_i == B_OSZ)                             kind_o = K_OSZ;
      else if (byte_i == B_REPNE || byte_i == B_REPE)  kind_o = K_REP;
      else if (|seg_hit)                               kind_o = K_SEG;
      else                                             kind_o = K_OPC;
   end

endmodule

// File: rtl/pfx_accum.sv
module pfx_accum
   import pfx_pkg::*;
#(
   parameter  int MAX_PFX = 14,
   localparam int CNT_W   = $clog2(MAX_PFX + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       take_i,
   input  logic       clr_i,
   input  kind_e      kind_i,
   input  logic [7:0] byte_i,
   output acc_t       acc_o,
   output logic       full_o
);

   logic [CNT_W-1:0] cnt_q;
   acc_t             acc_q, acc_d;

   // repeat bytes always take the class; 66 only fills an empty class
   always_comb begin
      acc_d = acc_q;
      unique case (kind_i)
         K_OSZ: begin
            acc_d.osz = 1'b1;
            if (acc_q.cls == CLS_NONE) acc_d.cls = B_OSZ;
         end
         K_REP: begin
            acc_d.rep = byte_i;
            acc_d.cls = byte_i;
         end
         K_SEG: begin
            acc_d.seg_f = 1'b1;
            acc_d.seg_b = byte_i;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
         acc_q <= ACC_CLR;
         cnt_q <= '0;
      end else if (take_i) begin
         acc_q <= acc_d;
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign acc_o  = acc_q;
   assign full_o = (cnt_q == CNT_W'(MAX_PFX));

endmodule

// File: rtl/pfx_vecload.sv
module pfx_vecload
   import pfx_pkg::*;
#(
   parameter logic [7:0] ESC_BYTE = 8'h0F,
   parameter logic [7:0] VLOAD_OP = 8'h6F
) (
   input  logic [7:0] opc_i,
   input  logic [7:0] esc_i,
   input  logic [7:0] cls_i,
   output logic       algn_o,
   output logic       unal_o
);

   logic hit;

   assign hit    = (opc_i == ESC_BYTE) && (esc_i == VLOAD_OP);
   assign algn_o = hit && (cls_i == B_OSZ);
   assign unal_o = hit && (cls_i == B_REPE);

endmodule

// File: rtl/pfx_scan.sv
module pfx_scan
   import pfx_pkg::*;
#(
   parameter  int         MAX_PFX     = 14,
   parameter  bit         CAPTURE_ESC = 1'b1,
   parameter  logic [7:0] ESC_BYTE    = 8'h0F,
   parameter  logic [7:0] VLOAD_OP    = 8'h6F,
   parameter  int         SHORT_SZ    = 2,
   parameter  int         LONG_SZ     = 4,
   localparam int         SZ_W        = $clog2(LONG_SZ + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_op4,
   input  logic            in_valid,
   output logic            in_ready,
   input  logic [7:0]      in_byte,
   output logic            out_valid,
   input  logic            out_ready,
   output logic [SZ_W-1:0] out_opsize,
   output logic [7:0]      out_rep,
   output logic [7:0]      out_class,
   output logic            out_seg_ovr,
   output logic [7:0]      out_seg,
   output logic [7:0]      out_opcode,
   output logic [7:0]      out_esc2,
   output logic            out_vload_aligned,
   output logic            out_vload_unaligned,
   output logic            out_fault
);

   if (MAX_PFX < 1 || MAX_PFX > 255) begin : g_bad_max
      $error("pfx_scan: MAX_PFX must lie in 1..255");
   end
   if (SHORT_SZ == LONG_SZ || SHORT_SZ < 1 || SHORT_SZ > LONG_SZ) begin : g_bad_sz
      $error("pfx_scan: SHORT_SZ must be positive and below LONG_SZ");
   end

   scan_st_e         st_q;
   kind_e            kind;
   acc_t             acc;
   logic             full, accept, is_pfx;
   logic             take, finish, fault_fin, to_esc;
   logic [SZ_W-1:0]  base_sz, alt_sz;

   logic             vld_q, fault_q, segf_q;
   logic [7:0]       opc_q, esc_q, cls_q, rep_q, segb_q;
   logic [SZ_W-1:0]  size_q;

   assign in_ready = ~vld_q;
   assign accept   = in_valid & in_ready;
   assign is_pfx   = (kind != K_OPC);
   assign base_sz  = cfg_op4 ? SZ_W'(LONG_SZ)  : SZ_W'(SHORT_SZ);
   assign alt_sz   = cfg_op4 ? SZ_W'(SHORT_SZ) : SZ_W'(LONG_SZ);

   pfx_classify u_cls (
      .byte_i (in_byte),
      .kind_o (kind)
   );

   pfx_accum #(.MAX_PFX(MAX_PFX)) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .take_i (take),
      .clr_i  (finish),
      .kind_i (kind),
      .byte_i (in_byte),
      .acc_o  (acc),
      .full_o (full)
   );

   always_comb begin
      take      = 1'b0;
      finish    = 1'b0;
      fault_fin = 1'b0;
      to_esc    = 1'b0;
      if (accept) begin
         if (st_q == S_ESC) begin
            finish = 1'b1;
         end else if (is_pfx) begin
            if (full) begin
               finish    = 1'b1;
               fault_fin = 1'b1;
            end else begin
               take = 1'b1;
            end
         end else if (CAPTURE_ESC && in_byte == ESC_BYTE) begin
            to_esc = 1'b1;
         end else begin
            finish = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= S_SCAN;
         vld_q   <= 1'b0;
         fault_q <= 1'b0;
         opc_q   <= 8'h00;
         esc_q   <= 8'h00;
         cls_q   <= 8'h00;
         rep_q   <= 8'h00;
         segf_q  <= 1'b0;
         segb_q  <= 8'h00;
         size_q  <= '0;
      end else begin
         if (to_esc)      st_q <= S_ESC;
         else if (finish) st_q <= S_SCAN;

         if (finish) begin
            vld_q   <= 1'b1;
            fault_q <= fault_fin;
            opc_q   <= (st_q == S_ESC) ? ESC_BYTE : in_byte;
            esc_q   <= (st_q == S_ESC) ? in_byte  : 8'h00;
            cls_q   <= acc.cls;
            rep_q   <= acc.rep;
            segf_q  <= acc.seg_f;
            segb_q  <= acc.seg_b;
            size_q  <= acc.osz ? alt_sz : base_sz;
         end else if (vld_q && out_ready) begin
            vld_q <= 1'b0;
         end
      end
   end

   if (CAPTURE_ESC) begin : g_vload
      pfx_vecload #(.ESC_BYTE(ESC_BYTE), .VLOAD_OP(VLOAD_OP)) u_vl (
         .opc_i  (opc_q),
         .esc_i  (esc_q),
         .cls_i  (cls_q),
         .algn_o (out_vload_aligned),
         .unal_o (out_vload_unaligned)
      );
   end else begin : g_no_vload
      assign out_vload_aligned   = 1'b0;
      assign out_vload_unaligned = 1'b0;
   end

   assign out_valid   = vld_q;
   assign out_fault   = fault_q;
   assign out_opcode  = opc_q;
   assign out_esc2    = esc_q;
   assign out_class   = cls_q;
   assign out_rep     = rep_q;
   assign out_seg_ovr = segf_q;
   assign out_seg     = segb_q;
   assign out_opsize  = size_q;

endmodule

// File: rtl/pfx_scan_chk.sv
module pfx_scan_chk
   import pfx_pkg::*;
#(
   parameter int SZ_W     = 3,
   parameter int SHORT_SZ = 2,
   parameter int LONG_SZ  = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            out_valid,
   input logic            out_ready,
   input logic [SZ_W-1:0] out_opsize,
   input logic [7:0]      out_rep,
   input logic [7:0]      out_class,
   input logic [7:0]      out_opcode,
   input logic [7:0]      out_esc2,
   input logic            out_vload_aligned,
   input logic            out_vload_unaligned,
   input logic            out_fault
);

   function automatic logic pfx_byte(input logic [7:0] b);
      logic hit;
      hit = (b == B_OSZ) || (b == B_REPNE) || (b == B_REPE);
      for (int i = 0; i < NUM_SEG; i++) begin
         if (b == SEG_CODES[i*8 +: 8]) hit = 1'b1;
      end
      return hit;
   endfunction

   // R2: a waiting result does not move
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_opcode) && $stable(out_class)
                                     && $stable(out_rep) && $stable(out_opsize)
                                     && $stable(out_esc2) && $stable(out_fault)));

   // R7: class is one of four codes
   a_r7_class_code: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_class == CLS_NONE || out_class == B_OSZ
                     || out_class == B_REPNE || out_class == B_REPE));

   // R5: a repeat prefix always owns the class
   a_r5_rep_class: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_rep != 8'h00) |-> (out_class == out_rep));

   // R3: only the two legal sizes
   a_r3_size: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (int'(out_opsize) == SHORT_SZ || int'(out_opsize) == LONG_SZ));

   // R8: the load variants exclude each other
   a_r8_vload_excl: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !(out_vload_aligned && out_vload_unaligned));

   // R7: opcode field holds a prefix byte only on a fault
   a_r7_opc_not_pfx: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_fault) |-> !pfx_byte(out_opcode));

   // R11: a fault carries the prefix byte and no escape byte
   a_r11_fault_shape: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_fault) |-> (pfx_byte(out_opcode) && out_esc2 == 8'h00));

endmodule

bind pfx_scan pfx_scan_chk #(.SZ_W(SZ_W), .SHORT_SZ(SHORT_SZ), .LONG_SZ(LONG_SZ)) u_chk (
   .clk                 (clk),
   .rst_n               (rst_n),
   .out_valid           (out_valid),
   .out_ready           (out_ready),
   .out_opsize          (out_opsize),
   .out_rep             (out_rep),
   .out_class           (out_class),
   .out_opcode          (out_opcode),
   .out_esc2            (out_esc2),
   .out_vload_aligned   (out_vload_aligned),
   .out_vload_unaligned (out_vload_unaligned),
   .out_fault           (out_fault)
);

// File: tb/test_pfx_scan.sv
`timescale 1ns/1ps
module test_pfx_scan;

   typedef struct packed {
      logic [7:0] opc;
      logic [7:0] esc;
      logic [7:0] cls;
      logic [7:0] rep;
      logic [2:0] size;
      logic       segf;
      logic [7:0] segb;
      logic       fault;
      logic       al;
      logic       un;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_op4 = 1'b1;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic [7:0] in_byte = 8'h00;
   logic       out_valid;
   logic       out_ready = 1'b0;
   logic [2:0] out_opsize;
   logic [7:0] out_rep, out_class, out_seg, out_opcode, out_esc2;
   logic       out_seg_ovr, out_vload_aligned, out_vload_unaligned, out_fault;

   int         n_cmp = 0;
   int         n_bad = 0;
   int         cyc   = 0;
   bit         done  = 1'b0;
   exp_t       expq[$];
   logic [7:0] bq[$];
   int unsigned rs = 32'h1234_5678;

   always #2 clk = ~clk;

   pfx_scan i_pfx_scan (
      .clk (clk), .rst_n (rst_n), .cfg_op4 (cfg_op4),
      .in_valid (in_valid), .in_ready (in_ready), .in_byte (in_byte),
      .out_valid (out_valid), .out_ready (out_ready),
      .out_opsize (out_opsize), .out_rep (out_rep), .out_class (out_class),
      .out_seg_ovr (out_seg_ovr), .out_seg (out_seg), .out_opcode (out_opcode),
      .out_esc2 (out_esc2), .out_vload_aligned (out_vload_aligned),
      .out_vload_unaligned (out_vload_unaligned), .out_fault (out_fault)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   function automatic bit is_pfx(input logic [7:0] b);
      return b == 8'h66 || b == 8'hF2 || b == 8'hF3 || b == 8'h26 || b == 8'h2E
          || b == 8'h36 || b == 8'h3E || b == 8'h64 || b == 8'h65;
   endfunction

   // behavioural reference from the requirements
   function automatic exp_t model(input logic [7:0] q[$], input bit d4);
      exp_t e;
      int   cnt = 0;
      bit   osz = 1'b0;
      e = '0;
      for (int i = 0; i < q.size(); i++) begin
         if (is_pfx(q[i])) begin
            if (cnt == 14) begin
               e.fault = 1'b1;
               e.opc   = q[i];
               break;
            end
            cnt++;
            if (q[i] == 8'h66) begin
               osz = 1'b1;
               if (e.cls == 8'h00) e.cls = 8'h66;
            end else if (q[i] == 8'hF2 || q[i] == 8'hF3) begin
               e.rep = q[i];
               e.cls = q[i];
            end else begin
               e.segf = 1'b1;
               e.segb = q[i];
            end
         end else begin
            e.opc = q[i];
            if (q[i] == 8'h0F && i + 1 < q.size()) e.esc = q[i+1];
            break;
         end
      end
      if (osz) e.size = d4 ? 3'd2 : 3'd4;
      else     e.size = d4 ? 3'd4 : 3'd2;
      e.al = (e.opc == 8'h0F) && (e.esc == 8'h6F) && (e.cls == 8'h66);
      e.un = (e.opc == 8'h0F) && (e.esc == 8'h6F) && (e.cls == 8'hF3);
      return e;
   endfunction

   task automatic send_insn();
      expq.push_back(model(bq, cfg_op4));
      for (int i = 0; i < bq.size(); i++) begin
         in_valid = 1'b1;
         in_byte  = bq[i];
         while (!in_ready) @(negedge clk);
         @(negedge clk);
      end
      in_valid = 1'b0;
   endtask

   task automatic drain();
      while (expq.size() != 0 || out_valid) @(negedge clk);
   endtask

   function automatic int unsigned nxt();
      rs = rs ^ (rs << 13);
      rs = rs ^ (rs >> 17);
      rs = rs ^ (rs << 5);
      return rs;
   endfunction

   // comparison on every clock
   always @(negedge clk) begin
      if (rst_n && !done) begin
         cyc++;
         chk("R2 in_ready vs out_valid", int'(in_ready), int'(!out_valid));
         out_ready = ((cyc % 5) != 2) && ((cyc % 7) != 3);
         if (out_valid) begin
            if (expq.size() == 0) begin
               chk("R7 unexpected result", 1, 0);
            end else begin
               chk("R7 opcode",            out_opcode, expq[0].opc);
               chk("R4 R6 R10 class",      out_class, expq[0].cls);
               chk("R5 R10 rep",           out_rep, expq[0].rep);
               chk("R3 opsize",            out_opsize, expq[0].size);
               chk("R9 R10 seg flag",      out_seg_ovr, expq[0].segf);
               chk("R9 seg byte",          out_seg, expq[0].segb);
               chk("R8 esc2",              out_esc2, expq[0].esc);
               chk("R8 aligned",           out_vload_aligned, expq[0].al);
               chk("R8 unaligned",         out_vload_unaligned, expq[0].un);
               chk("R11 R6 fault",         out_fault, expq[0].fault);
               if (out_ready) void'(expq.pop_front());
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL R2 watchdog: actual hung expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 out_valid", int'(out_valid), 0);
      chk("R1 in_ready",  int'(in_ready), 1);

      // R8 R4 R6: all orderings of 66/F3 before 0F 6F
      bq = '{8'h66, 8'h0F, 8'h6F};                send_insn();
      bq = '{8'hF3, 8'h0F, 8'h6F};                send_insn();
      bq = '{8'h66, 8'h66, 8'h0F, 8'h6F};         send_insn();
      bq = '{8'h66, 8'hF3, 8'h0F, 8'h6F};         send_insn();
      bq = '{8'hF3, 8'h66, 8'h0F, 8'h6F};         send_insn();
      bq = '{8'hF3, 8'hF3, 8'h0F, 8'h6F};         send_insn();
      bq = '{8'h66, 8'h66, 8'h66, 8'h0F, 8'h6F};  send_insn();
      bq = '{8'h66, 8'h66, 8'hF3, 8'h0F, 8'h6F};  send_insn();
      bq = '{8'h66, 8'hF3, 8'h66, 8'h0F, 8'h6F};  send_insn();
      bq = '{8'h66, 8'hF3, 8'hF3, 8'h0F, 8'h6F};  send_insn();
      bq = '{8'hF3, 8'h66, 8'h66, 8'h0F, 8'h6F};  send_insn();
      bq = '{8'hF3, 8'h66, 8'hF3, 8'h0F, 8'h6F};  send_insn();
      bq = '{8'hF3, 8'hF3, 8'h66, 8'h0F, 8'h6F};  send_insn();
      bq = '{8'hF3, 8'hF3, 8'hF3, 8'h0F, 8'h6F};  send_insn();
      bq = '{8'h0F, 8'h6F};                       send_insn();
      // R5 R6: F2 class and last repeat wins
      bq = '{8'hF2, 8'h66, 8'h0F, 8'h10};         send_insn();
      bq = '{8'hF3, 8'hF2, 8'hA4};                send_insn();
      bq = '{8'hF2, 8'hF3, 8'h0F, 8'h6F};         send_insn();
      // R9 segments, last wins
      bq = '{8'h2E, 8'h64, 8'h8B};                send_insn();
      bq = '{8'h26, 8'h36, 8'h3E, 8'h65, 8'h90};  send_insn();
      bq = '{8'h90};                              send_insn();
      // R11 boundary: 14 prefixes then opcode, no fault
      bq.delete();
      repeat (14) bq.push_back(8'h66);
      bq.push_back(8'h90);
      send_insn();
      // R11: 15th prefix faults
      bq.delete();
      repeat (3) bq.push_back(8'h66);
      bq.push_back(8'hF3);
      repeat (10) bq.push_back(8'h2E);
      bq.push_back(8'h64);
      send_insn();
      // R10: fresh state after fault
      bq = '{8'h0F, 8'h6F};                       send_insn();
      drain();

      // R3: 2-byte default
      cfg_op4 = 1'b0;
      bq = '{8'h66, 8'h90};                       send_insn();
      bq = '{8'h90};                              send_insn();
      bq = '{8'h66, 8'h66, 8'h0F, 8'h6F};         send_insn();
      drain();

      // mixed random instructions
      for (int n = 0; n < 300; n++) begin
         int np;
         int pick;
         if (n == 150) begin
            drain();
            cfg_op4 = 1'b1;
         end
         bq.delete();
         np = int'(nxt() % 16);
         for (int k = 0; k < np; k++) begin
            pick = int'(nxt() % 6);
            case (pick)
               0, 1: bq.push_back(8'h66);
               2:    bq.push_back(8'hF3);
               3:    bq.push_back(8'hF2);
               4:    bq.push_back(8'h2E);
               default: bq.push_back(8'h65);
            endcase
         end
         if (np < 15) begin
            pick = int'(nxt() % 4);
            case (pick)
               0, 1: begin bq.push_back(8'h0F); bq.push_back(8'h6F); end
               2:    begin bq.push_back(8'h0F); bq.push_back(8'h10); end
               default: bq.push_back(8'hC3);
            endcase
         end
         send_insn();
      end
      drain();
      repeat (4) @(negedge clk);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule